// File: doc/BRIEF.md
# Synchronous Flow-Through Static Memory with Byte-Lane Writes

This block is a single-clock static memory. Each word is split into byte lanes, and each lane holds one data byte plus its parity bit. On every rising clock edge the block captures the address, the write data, the chip enable, the address strobe and one write enable per lane. A low address strobe opens a new access. While the strobe stays high, later cycles reuse the address already held in the register.

Read data comes straight from the array at the registered address. It appears in the same cycle that follows the edge, with no output pipeline register. An output enable that is not clocked gates the data bus. The tri-state bus is modelled as three signals: a write data input, a read data output and a drive flag.

A write starts on the edge that samples a low lane enable. The array is updated at the next edge, so the write finishes inside its own cycle and needs no other strobe.

The controller is a three-state machine:
- `ST_DESEL`: deselected, bus released, no writes.
- `ST_READ`: active read of the registered word.
- `ST_WRITE`: active write of the enabled lanes.

The next state is decided on every edge:
- strobe low and chip enable high leads to `ST_DESEL`.
- strobe low and chip enable low leads to `ST_WRITE` if any lane enable is low, and to `ST_READ` otherwise. The address is loaded on this edge.
- strobe high keeps `ST_DESEL` if the block was deselected. Otherwise it leads to `ST_WRITE` or `ST_READ` according to the lane enables, at the held address.

Top module: `fts_sram`

## Requirements
- R1: After reset the block is in `ST_DESEL`, `drive_o` is 0 and `rdata_o` is 0, whatever `oe_n_i` is.
- R2: An edge with `strobe_n_i`=0 and `ce_n_i`=1 deselects the block for the next cycle: `drive_o`=0 and `rdata_o`=0.
- R3: An edge with `strobe_n_i`=0, `ce_n_i`=0 and all lane enables high starts a read at `addr_i`. In the cycle right after that edge, with `oe_n_i`=0, `drive_o`=1 and `rdata_o` equals the stored word.
- R4: An edge with `strobe_n_i`=1 keeps the registered address and ignores `ce_n_i`. An active block stays active and a deselected block stays deselected.
- R5: An edge counts as a write when any bit of `bwe_n_i` is 0. Only the lanes whose bit is 0 change. Lane k is bits [9k+8:9k] of a word, and its parity bit is bit 9k+8, written under the same enable.
- R6: `oe_n_i` is active low and acts without a clock. In an active read cycle, `drive_o` follows `!oe_n_i` at once. While `drive_o`=0, `rdata_o` is 0.
- R7: During a write cycle `drive_o`=0, even with `oe_n_i`=0.
- R8: A write sampled at one edge is stored by the next edge. A read started at that next edge returns the new data.
- R9: While the block is deselected, low lane enables store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control registers |
| addr_i | input | ADDR_W | Word address, captured when a new access starts |
| wdata_i | input | LANES*(BYTE_W+1) | Write data; each lane is a byte with its parity bit on top |
| ce_n_i | input | 1 | Active-low chip enable, used only when the strobe is low |
| strobe_n_i | input | 1 | Active-low address strobe |
| bwe_n_i | input | LANES | Active-low write enable, one bit per lane |
| oe_n_i | input | 1 | Active-low output enable, not clocked |
| rdata_o | output | LANES*(BYTE_W+1) | Read data; 0 when the bus is not driven |
| drive_o | output | 1 | 1 when the block drives the data bus |

## Verification
Suppose the state register or the held address is wrong. Then, in the cycle right after the edge, `drive_o` is set when it should be clear, or `rdata_o` shows a word from another location. Suppose a lane write mask is wrong. Then the error stays in the array and shows up on the next read of that word, one or more cycles later, as a wrong byte or a wrong parity bit. The sweeps read back every address after each kind of write, so such errors are seen within one pass over the array.

// File: rtl/fts_pkg.sv
package fts_pkg;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } fts_state_e;

endpackage

// File: rtl/fts_ctrl.sv
module fts_ctrl
    import fts_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [LANES*LANE_W-1:0]   wdata_i,
    input  logic                      ce_n_i,
    input  logic                      strobe_n_i,
    input  logic [LANES-1:0]          bwe_n_i,
    input  logic                      oe_n_i,
    output logic [ADDR_W-1:0]         addr_o,
    output logic [LANES*LANE_W-1:0]   wdata_o,
    output logic [LANES-1:0]          lane_we_o,
    output logic                      drive_o
);

    localparam logic [LANES-1:0] NO_WRITE = '1;

    fts_state_e               state_q;
    fts_state_e               state_d;
    logic [ADDR_W-1:0]        addr_q;
    logic [LANES-1:0]         bwe_n_q;
    logic [LANES*LANE_W-1:0]  wdata_q;
    logic                     wr_req;

    assign wr_req = (bwe_n_i != NO_WRITE);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        if (!strobe_n_i) begin
            if (ce_n_i) begin
                state_d = ST_DESEL;
            end else begin
                state_d = wr_req ? ST_WRITE : ST_READ;
            end
        end else begin
            unique case (state_q)
                ST_DESEL: state_d = ST_DESEL;
                ST_READ,
                ST_WRITE: state_d = wr_req ? ST_WRITE : ST_READ;
                default:  state_d = ST_DESEL;
            endcase
        end
    end

    // State register and captured inputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
            addr_q  <= '0;
            bwe_n_q <= NO_WRITE;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            bwe_n_q <= bwe_n_i;
            wdata_q <= wdata_i;
            if (!strobe_n_i && !ce_n_i) begin
                addr_q <= addr_i;
            end
        end
    end

    // Outputs per state
    always_comb begin
        drive_o   = 1'b0;
        lane_we_o = '0;
        unique case (state_q)
            ST_DESEL: begin
                drive_o   = 1'b0;
                lane_we_o = '0;
            end
            ST_READ: begin
                drive_o   = !oe_n_i;
                lane_we_o = '0;
            end
            ST_WRITE: begin
                drive_o   = 1'b0;
                lane_we_o = ~bwe_n_q;
            end
            default: begin
                drive_o   = 1'b0;
                lane_we_o = '0;
            end
        endcase
    end

    assign addr_o  = addr_q;
    assign wdata_o = wdata_q;

endmodule

// File: rtl/fts_array.sv
module fts_array #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [LANES*LANE_W-1:0]   wdata_i,
    input  logic [LANES-1:0]          lane_we_i,
    output logic [LANES*LANE_W-1:0]   rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we_i[g]) begin
                mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
            end
        end

        assign rdata_o[g*LANE_W +: LANE_W] = mem[addr_i];
    end

endmodule

// File: rtl/fts_sram.sv
module fts_sram #(
    parameter int ADDR_W = 4,
    parameter int BYTE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [LANES*(BYTE_W+1)-1:0]     wdata_i,
    input  logic                            ce_n_i,
    input  logic                            strobe_n_i,
    input  logic [LANES-1:0]                bwe_n_i,
    input  logic                            oe_n_i,
    output logic [LANES*(BYTE_W+1)-1:0]     rdata_o,
    output logic                            drive_o
);

    localparam int LANE_W = BYTE_W + 1;
    localparam int WORD_W = LANES * LANE_W;

    logic [ADDR_W-1:0] cur_addr;
    logic [WORD_W-1:0] cur_wdata;
    logic [LANES-1:0]  lane_we;
    logic [WORD_W-1:0] arr_rdata;

    fts_ctrl #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .ce_n_i     (ce_n_i),
        .strobe_n_i (strobe_n_i),
        .bwe_n_i    (bwe_n_i),
        .oe_n_i     (oe_n_i),
        .addr_o     (cur_addr),
        .wdata_o    (cur_wdata),
        .lane_we_o  (lane_we),
        .drive_o    (drive_o)
    );

    fts_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) array_i (
        .clk       (clk),
        .addr_i    (cur_addr),
        .wdata_i   (cur_wdata),
        .lane_we_i (lane_we),
        .rdata_o   (arr_rdata)
    );

    // Bus is released (zero) whenever not driven
    assign rdata_o = drive_o ? arr_rdata : '0;

endmodule

// File: rtl/fts_sram_chk.sv
module fts_sram_chk #(
    parameter int ADDR_W = 4,
    parameter int BYTE_W = 8,
    parameter int LANES  = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        ce_n_i,
    input logic                        strobe_n_i,
    input logic [LANES-1:0]            bwe_n_i,
    input logic                        oe_n_i,
    input logic [LANES*(BYTE_W+1)-1:0] rdata_o,
    input logic                        drive_o
);

    localparam logic [LANES-1:0] NO_WR = '1;

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> !drive_o);

    p_desel_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n_i && ce_n_i) |=> !drive_o);

    p_start_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n_i && !ce_n_i && bwe_n_i == NO_WR) |=> (oe_n_i || drive_o));

    p_keep_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_o && strobe_n_i && bwe_n_i == NO_WR) |=> (oe_n_i || drive_o));

    p_oe_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> !drive_o);

    p_bus_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_o |-> (rdata_o == '0));

    p_write_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bwe_n_i != NO_WR) |=> !drive_o);

endmodule

bind fts_sram fts_sram_chk #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W),
    .LANES  (LANES)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n_i     (ce_n_i),
    .strobe_n_i (strobe_n_i),
    .bwe_n_i    (bwe_n_i),
    .oe_n_i     (oe_n_i),
    .rdata_o    (rdata_o),
    .drive_o    (drive_o)
);

// File: tb/fts_sram_tb_top.sv
module fts_sram_tb_top;

    localparam int AW    = 4;
    localparam int BW    = 8;
    localparam int NL    = 2;
    localparam int LW    = BW + 1;
    localparam int WW    = NL * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [WW-1:0] wdata_i = '0;
    logic          ce_n_i = 1'b1;
    logic          strobe_n_i = 1'b1;
    logic [NL-1:0] bwe_n_i = '1;
    logic          oe_n_i = 1'b0;
    logic [WW-1:0] rdata_o;
    logic          drive_o;

    int n_cmp = 0;
    int n_bad = 0;

    // Bench model state built from the requirements
    logic [WW-1:0] exp_mem [DEPTH];
    int            m_state = 0;      // 0 deselected, 1 read, 2 write
    logic [AW-1:0] m_addr = '0;
    logic [NL-1:0] m_bwe = '1;
    logic [WW-1:0] m_wd = '0;

    always #10 clk = ~clk;

    fts_sram #(.ADDR_W(AW), .BYTE_W(BW), .LANES(NL)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
        .ce_n_i(ce_n_i), .strobe_n_i(strobe_n_i), .bwe_n_i(bwe_n_i),
        .oe_n_i(oe_n_i), .rdata_o(rdata_o), .drive_o(drive_o)
    );

    function automatic logic [WW-1:0] pat(input int a, input int k);
        return WW'((a * 3571 + k * 9137 + 77) % (1 << WW));
    endfunction

    task automatic check(input string tag, input logic [WW-1:0] got_d,
                         input logic got_v, input logic [WW-1:0] exp_d,
                         input logic exp_v);
        n_cmp++;
        if (got_v !== exp_v || got_d !== exp_d) begin
            n_bad++;
            $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
                     tag, got_v, got_d, exp_v, exp_d);
        end
    endtask

    // One bus cycle: drive at negedge, model the edge, sample 5 ns after it
    task automatic cyc(input string tag, input logic sn, input logic cn,
                       input int a, input logic [NL-1:0] bw,
                       input logic [WW-1:0] wd, input logic oe);
        logic          ev;
        logic [WW-1:0] ed;
        @(negedge clk);
        strobe_n_i = sn; ce_n_i = cn; addr_i = AW'(a);
        bwe_n_i = bw; wdata_i = wd; oe_n_i = oe;
        @(posedge clk);
        // commit of the previous cycle's write (R8)
        if (m_state == 2) begin
            for (int k = 0; k < NL; k++)
                if (!m_bwe[k]) exp_mem[m_addr][k*LW +: LW] = m_wd[k*LW +: LW];
        end
        if (!sn) begin
            if (cn) m_state = 0;
            else begin
                m_addr  = AW'(a);
                m_state = (bw != '1) ? 2 : 1;
            end
        end else if (m_state != 0) begin
            m_state = (bw != '1) ? 2 : 1;
        end
        m_bwe = bw; m_wd = wd;
        #5;
        ev = (m_state == 1) && !oe;
        ed = ev ? exp_mem[m_addr] : '0;
        check(tag, rdata_o, drive_o, ed, ev);
    endtask

    initial begin : watchdog
        #2000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run hung, drive=%0b expected completion", drive_o);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        for (int a = 0; a < DEPTH; a++) exp_mem[a] = '0;
        // R1: reset state with output enable active
        repeat (3) @(posedge clk);
        #5 check("R1 reset", rdata_o, drive_o, '0, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        // R1/R4: strobe high after reset stays deselected, ce ignored
        cyc("R4 desel hold", 1'b1, 1'b0, 3, 2'b11, '0, 1'b0);
        cyc("R4 desel hold", 1'b1, 1'b1, 5, 2'b11, '0, 1'b0);
        // R5/R7: full-word writes to every address, some with oe low
        for (int a = 0; a < DEPTH; a++)
            cyc("R7 write hiz", 1'b0, 1'b0, a, 2'b00, pat(a, 0), a[0]);
        // R3/R8: new-address reads of every word
        for (int a = 0; a < DEPTH; a++)
            cyc("R3 read", 1'b0, 1'b0, a, 2'b11, '0, 1'b0);
        // R5/R4: lane 0 at new address, lane 1 continued, then continued read
        for (int a = 0; a < DEPTH; a++) begin
            cyc("R5 lane0 wr", 1'b0, 1'b0, a, 2'b10, pat(a, 1), 1'b1);
            cyc("R5 lane1 wr", 1'b1, 1'b1, (a + 7) % DEPTH, 2'b01, pat(a, 2), 1'b0);
            cyc("R8 readback", 1'b1, 1'b1, (a + 9) % DEPTH, 2'b11, '0, 1'b0);
            cyc("R4 hold rd", 1'b1, 1'b0, (a + 3) % DEPTH, 2'b11, '0, 1'b0);
        end
        // R5: parity bits only, on lane 1
        for (int a = 0; a < DEPTH; a += 3) begin
            cyc("R5 parity wr", 1'b0, 1'b0, a, 2'b01, WW'(1 << (2*LW - 1)), 1'b1);
            cyc("R5 parity rd", 1'b1, 1'b0, 0, 2'b11, '0, 1'b0);
        end
        // R2/R9: deselect, then write attempts while deselected
        cyc("R2 deselect", 1'b0, 1'b1, 4, 2'b11, '0, 1'b0);
        cyc("R9 desel wr", 1'b1, 1'b0, 4, 2'b00, '1, 1'b0);
        cyc("R9 desel wr", 1'b1, 1'b1, 6, 2'b01, '1, 1'b0);
        cyc("R2 desel strobe", 1'b0, 1'b1, 6, 2'b00, '1, 1'b0);
        for (int a = 0; a < DEPTH; a++)
            cyc("R9 untouched", 1'b0, 1'b0, a, 2'b11, '0, 1'b0);
        // R6: output enable acts without a clock edge
        cyc("R6 oe high", 1'b0, 1'b0, 2, 2'b11, '0, 1'b1);
        #2 oe_n_i = 1'b0;
        #1 check("R6 oe fall", rdata_o, drive_o, exp_mem[2], 1'b1);
        #2 oe_n_i = 1'b1;
        #1 check("R6 oe rise", rdata_o, drive_o, '0, 1'b0);
        // R7: oe low during a write at held address
        cyc("R7 wr oe low", 1'b1, 1'b0, 0, 2'b00, pat(2, 5), 1'b0);
        cyc("R8 after wr", 1'b1, 1'b0, 0, 2'b11, '0, 1'b0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule